// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Unit

This block gathers the interrupt conditions of a 16550-compatible UART and reports the most urgent one that is pending as an 8-bit interrupt status word. There are seven sources, ranked from most to least urgent: receive line error, receive data available, receive timeout, transmitter holding empty, modem line change, flow-control pause (Xoff) or special character, and handshake line change. The last two are extended sources. They only count when the extended-features flag is set. The block also drives an active-high interrupt request.

Sources that are signalled by a pulse are held in internal flags until their own clearing action happens. Depending on the source, that action is a read of the line-status register, a read of the modem-status register, or a read of the status word itself while that source is the one being reported. The data-available condition is not held. It is evaluated every cycle from the receive FIFO fill level and the trigger level. The timeout flag is cleared by a data pop that takes the fill level below the threshold. The surrounding UART supplies the condition pulses, the enable mask, the FIFO level and the register-read strobes. The FIFOs and shift registers are not part of this block.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the status word is 8'h01 with FIFOs disabled, and `irq` is 0.
- R2: The most urgent pending source sets status bits [5:0]. Source indices and codes are: 0 line error = 000110, 1 data available = 000100, 2 timeout = 001100, 3 holding empty = 000010, 4 modem change = 000000, 5 Xoff/special = 010000, 6 handshake change = 100000. A lower index wins. With nothing pending, bits [5:0] are 000001.
- R3: `irq` is the inverse of status bit 0. It is 1 exactly when some source is pending.
- R4: Sources 5 and 6 count only while `enh_en` is 1. While `enh_en` is 0, status bits [5:4] are 0.
- R5: A `line_evt` pulse holds the line-error source pending until a cycle with `lsr_rd`.
- R6: Data available is pending while `rx_level >= thr`. The threshold `thr` is `rx_trig` when `fifo_en` is 1, and 1 otherwise. This source has no held state.
- R7: A `tmo_evt` pulse holds the timeout source pending until a cycle where `rx_pop` is 1 and `rx_level <= thr`.
- R8: A `tx_evt` pulse holds the holding-empty source pending until a cycle where `isr_rd` is 1 and index 3 is the source being reported.
- R9: The modem-change source (`modem_evt`) and the handshake-change source (`flow_evt`) are both held until a cycle with `msr_rd`.
- R10: An `xoff_evt` pulse does two things: it holds source 5 pending until an `isr_rd` that reports index 5, and it sets a pause flag that stays set until `xon_evt`. While the pause flag is set and `enh_en` is 1, status bit 4 is 1, whatever else is shown. If `xoff_evt` and `xon_evt` arrive in the same cycle, the flag is set.
- R11: Status bits [7:6] are 11 when `fifo_en` is 1 and 00 when it is 0.
- R12: A set pulse that arrives in the same cycle as that source's clearing action leaves the source pending.
- R13: A source counts only while its bit in `src_en` is set. A masked source is still recorded, and it appears once the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled |
| enh_en | input | 1 | Extended features enabled |
| src_en | input | 7 | Per-source interrupt enable, indexed by priority |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| rx_pop | input | 1 | Receive data read strobe |
| line_evt | input | 1 | Receive line error detected |
| tmo_evt | input | 1 | Receive timeout detected |
| tx_evt | input | 1 | Transmit holding register became empty |
| modem_evt | input | 1 | Modem input changed |
| xoff_evt | input | 1 | Xoff or special character matched |
| xon_evt | input | 1 | Xon character matched |
| flow_evt | input | 1 | Handshake line changed |
| isr_rd | input | 1 | Status word read strobe |
| lsr_rd | input | 1 | Line-status read strobe |
| msr_rd | input | 1 | Modem-status read strobe |
| isr | output | 8 | Interrupt status word |
| irq | output | 1 | Interrupt request, active high |

## Verification
A set pulse and the read that clears the same source can arrive in the same cycle. Directed steps produce this for the line-error source (`line_evt` with `lsr_rd`) and for the pause flag (`xoff_evt` with `xon_evt`). The randomized phase also produces it often, for every source, because events and read strobes are drawn independently. The result is judged against a bench model in which a set always wins. A second overlap is a status read arriving while a more urgent source masks the holding-empty source. The model then expects that source to stay pending, because it was not the one reported.

// File: rtl/uart_isr_pkg.sv
package uart_isr_pkg;
   localparam int NSRC = 7;

   localparam int IX_LINE  = 0;
   localparam int IX_RXRDY = 1;
   localparam int IX_TMO   = 2;
   localparam int IX_TXE   = 3;
   localparam int IX_MODEM = 4;
   localparam int IX_XOFF  = 5;
   localparam int IX_FLOW  = 6;

   function automatic logic [5:0] src_code(input int idx);
      case (idx)
         IX_LINE:  return 6'b000110;
         IX_RXRDY: return 6'b000100;
         IX_TMO:   return 6'b001100;
         IX_TXE:   return 6'b000010;
         IX_MODEM: return 6'b000000;
         IX_XOFF:  return 6'b010000;
         IX_FLOW:  return 6'b100000;
         default:  return 6'b000001;
      endcase
   endfunction
endpackage

// File: rtl/isr_evt_latch.sv
module isr_evt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~clr_i);
   end

   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
endmodule

// File: rtl/isr_rx_watch.sv
module isr_rx_watch #(
   parameter int LVL_W = 6
) (
   input  logic             fifo_en,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_trig,
   input  logic             rx_pop,
   output logic             ready_o,
   output logic             tmo_clr_o
);
   localparam logic [LVL_W-1:0] ONE = LVL_W'(1);
   logic [LVL_W-1:0] thr;

   assign thr       = fifo_en ? rx_trig : ONE;
   assign ready_o   = (rx_level >= thr);
   assign tmo_clr_o = rx_pop & (rx_level <= thr);
endmodule

// File: rtl/isr_prio_pick.sv
module isr_prio_pick #(
   parameter int N = 7
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o,
   output logic         any_o
);
   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt_o[i]       = req_i[i] & ~blocked[i];
      assign blocked[i + 1] = blocked[i] | req_i[i];
   end

   assign any_o = blocked[N];

   a_r2_onehot_grant: assert final ($onehot0(gnt_o));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
   import uart_isr_pkg::*;
#(
   parameter int LVL_W        = 6,
   parameter bit ENH_SUPPORT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             enh_en,
   input  logic [6:0]       src_en,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] rx_trig,
   input  logic             rx_pop,
   input  logic             line_evt,
   input  logic             tmo_evt,
   input  logic             tx_evt,
   input  logic             modem_evt,
   input  logic             xoff_evt,
   input  logic             xon_evt,
   input  logic             flow_evt,
   input  logic             isr_rd,
   input  logic             lsr_rd,
   input  logic             msr_rd,
   output logic [7:0]       isr,
   output logic             irq
);
   if (LVL_W < 1 || LVL_W > 16) begin : g_bad_lvl
      $error("uart_irq_status: LVL_W out of range");
   end
   if (NSRC != 7) begin : g_bad_nsrc
      $error("uart_irq_status: source count must be 7");
   end

   logic [NSRC-1:0] cond, pend, gnt;
   logic            any_pend;
   logic            rx_ready, tmo_clr;
   logic            line_q, tmo_q, tx_q, modem_q;
   logic            xoff_q, flow_q, stk_q, enh_act;

   isr_rx_watch #(.LVL_W(LVL_W)) u_rx (
      .fifo_en   (fifo_en),
      .rx_level  (rx_level),
      .rx_trig   (rx_trig),
      .rx_pop    (rx_pop),
      .ready_o   (rx_ready),
      .tmo_clr_o (tmo_clr)
   );

   isr_evt_latch u_line  (.clk, .rst_n, .set_i(line_evt),  .clr_i(lsr_rd),  .q_o(line_q));
   isr_evt_latch u_tmo   (.clk, .rst_n, .set_i(tmo_evt),   .clr_i(tmo_clr), .q_o(tmo_q));
   isr_evt_latch u_tx    (.clk, .rst_n, .set_i(tx_evt),
                          .clr_i(isr_rd & gnt[IX_TXE]), .q_o(tx_q));
   isr_evt_latch u_modem (.clk, .rst_n, .set_i(modem_evt), .clr_i(msr_rd),  .q_o(modem_q));

   if (ENH_SUPPORT) begin : g_enh
      isr_evt_latch u_xoff (.clk, .rst_n, .set_i(xoff_evt),
                            .clr_i(isr_rd & gnt[IX_XOFF]), .q_o(xoff_q));
      isr_evt_latch u_stk  (.clk, .rst_n, .set_i(xoff_evt), .clr_i(xon_evt), .q_o(stk_q));
      isr_evt_latch u_flow (.clk, .rst_n, .set_i(flow_evt), .clr_i(msr_rd),  .q_o(flow_q));
      assign enh_act = enh_en;
   end else begin : g_noenh
      logic unused_enh;
      assign unused_enh = ^{xoff_evt, xon_evt, flow_evt, enh_en};
      assign xoff_q  = 1'b0;
      assign stk_q   = 1'b0;
      assign flow_q  = 1'b0;
      assign enh_act = 1'b0;
   end

   assign cond[IX_LINE]  = line_q;
   assign cond[IX_RXRDY] = rx_ready;
   assign cond[IX_TMO]   = tmo_q;
   assign cond[IX_TXE]   = tx_q;
   assign cond[IX_MODEM] = modem_q;
   assign cond[IX_XOFF]  = xoff_q;
   assign cond[IX_FLOW]  = flow_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_pend
      if (i >= IX_XOFF) begin : g_ext
         assign pend[i] = cond[i] & src_en[i] & enh_act;
      end else begin : g_base
         assign pend[i] = cond[i] & src_en[i];
      end
   end

   isr_prio_pick #(.N(NSRC)) u_pick (
      .req_i (pend),
      .gnt_o (gnt),
      .any_o (any_pend)
   );

   logic [5:0] code;
   always_comb begin
      code = 6'b000000;
      for (int i = 0; i < NSRC; i++) begin
         if (gnt[i]) code = code | src_code(i);
      end
      if (!any_pend) code = 6'b000001;
      code[4] = code[4] | (enh_act & stk_q);
   end

   assign isr = {fifo_en, fifo_en, code};
   assign irq = ~isr[0];

   a_r3_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (|pend));
   a_r4_ext_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      !enh_en |-> (isr[5:4] == 2'b00));
   a_r5_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !line_evt) |=> !line_q);
   a_r7_tmo_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && fifo_en && (rx_level <= rx_trig) && !tmo_evt) |=> !tmo_q);
   a_r8_tx_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_q && !isr_rd) |=> tx_q);
   a_r9_msr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd && !modem_evt) |=> !modem_q);
   a_r11_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
      isr[7:6] == {fifo_en, fifo_en});
   a_r1_line_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q && src_en[0]) |-> (isr[5:0] == 6'b000110 || isr[5:0] == 6'b010110));
endmodule

// File: tb/uart_irq_status_test.sv
module uart_irq_status_test;
   localparam int LVL_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_en, enh_en, rx_pop;
   logic [6:0] src_en;
   logic [LVL_W-1:0] rx_level, rx_trig;
   logic line_evt, tmo_evt, tx_evt, modem_evt, xoff_evt, xon_evt, flow_evt;
   logic isr_rd, lsr_rd, msr_rd;
   logic [7:0] isr;
   logic irq;

   int n_chk = 0;
   int n_bad = 0;

   // model state
   bit m_line, m_tmo, m_tx, m_modem, m_xoff, m_stk, m_flow;

   always #5 clk = ~clk;

   uart_irq_status #(.LVL_W(LVL_W), .ENH_SUPPORT(1'b1)) uut (
      .clk, .rst_n, .fifo_en, .enh_en, .src_en, .rx_level, .rx_trig, .rx_pop,
      .line_evt, .tmo_evt, .tx_evt, .modem_evt, .xoff_evt, .xon_evt, .flow_evt,
      .isr_rd, .lsr_rd, .msr_rd, .isr, .irq
   );

   function automatic int thr_now();
      return fifo_en ? int'(rx_trig) : 1;
   endfunction

   function automatic int rep_idx();
      bit [6:0] c;
      c = {m_flow, m_xoff, m_modem, m_tx, m_tmo, (int'(rx_level) >= thr_now()), m_line};
      for (int i = 0; i < 7; i++) begin
         if (c[i] && src_en[i] && (i < 5 || enh_en)) return i;
      end
      return -1;
   endfunction

   function automatic logic [7:0] exp_isr();
      logic [5:0] v;
      case (rep_idx())
         0: v = 6'b000110;
         1: v = 6'b000100;
         2: v = 6'b001100;
         3: v = 6'b000010;
         4: v = 6'b000000;
         5: v = 6'b010000;
         6: v = 6'b100000;
         default: v = 6'b000001;
      endcase
      v[4] = v[4] | (enh_en & m_stk);
      return {fifo_en, fifo_en, v};
   endfunction

   task automatic clear_pulses();
      rx_pop = 0; line_evt = 0; tmo_evt = 0; tx_evt = 0; modem_evt = 0;
      xoff_evt = 0; xon_evt = 0; flow_evt = 0; isr_rd = 0; lsr_rd = 0; msr_rd = 0;
   endtask

   // check current outputs, then advance one clock and update the model
   task automatic cycle(input string tag);
      logic [7:0] e;
      int rep;
      #1;
      e = exp_isr();
      rep = rep_idx();
      n_chk++;
      if (isr !== e) begin
         n_bad++;
         $display("FAIL %s isr actual=%h expected=%h", tag, isr, e);
      end
      n_chk++;
      if (irq !== ~e[0]) begin
         n_bad++;
         $display("FAIL R3 (%s) irq actual=%b expected=%b", tag, irq, ~e[0]);
      end
      @(posedge clk);
      m_line  = line_evt  | (m_line  & ~lsr_rd);
      m_tmo   = tmo_evt   | (m_tmo   & ~(rx_pop && int'(rx_level) <= thr_now()));
      m_tx    = tx_evt    | (m_tx    & ~(isr_rd && rep == 3));
      m_modem = modem_evt | (m_modem & ~msr_rd);
      m_xoff  = xoff_evt  | (m_xoff  & ~(isr_rd && rep == 5));
      m_stk   = xoff_evt  | (m_stk   & ~xon_evt);
      m_flow  = flow_evt  | (m_flow  & ~msr_rd);
      @(negedge clk);
      clear_pulses();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      int seed;
      seed = 32'h5A17;
      void'($urandom(seed));
      clear_pulses();
      fifo_en = 0; enh_en = 0; src_en = '0; rx_level = '0; rx_trig = 6'd1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cycle("R1");

      // R5 line error latch and clear
      src_en = 7'h7F;
      line_evt = 1; cycle("R5");
      cycle("R5");
      // R12 set in same cycle as lsr read
      line_evt = 1; lsr_rd = 1; cycle("R12");
      cycle("R12");
      lsr_rd = 1; cycle("R5");
      cycle("R5");

      // R6 / R11 data available vs trigger
      fifo_en = 1; rx_trig = 6'd4; rx_level = 6'd3; cycle("R6");
      rx_level = 6'd4; cycle("R6");
      fifo_en = 0; rx_level = 6'd1; cycle("R11");
      fifo_en = 1; rx_level = 6'd2; cycle("R11");

      // R7 timeout
      tmo_evt = 1; cycle("R7");
      cycle("R7");
      rx_level = 6'd5; rx_pop = 1; cycle("R7");
      rx_level = 6'd2; rx_pop = 1; cycle("R7");
      cycle("R7");

      // R8 holding empty, masked by a higher source on read
      tx_evt = 1; line_evt = 1; cycle("R8");
      isr_rd = 1; cycle("R8");
      lsr_rd = 1; cycle("R8");
      isr_rd = 1; cycle("R8");
      cycle("R8");

      // R4 / R10 extended sources
      xoff_evt = 1; cycle("R4");
      cycle("R4");
      enh_en = 1; cycle("R10");
      isr_rd = 1; cycle("R10");
      cycle("R10");
      xon_evt = 1; xoff_evt = 1; cycle("R10");
      isr_rd = 1; cycle("R10");
      xon_evt = 1; cycle("R10");
      cycle("R10");

      // R9 modem and handshake change
      modem_evt = 1; flow_evt = 1; cycle("R9");
      cycle("R9");
      msr_rd = 1; cycle("R9");
      cycle("R9");
      flow_evt = 1; cycle("R9");
      enh_en = 0; cycle("R4");
      enh_en = 1; msr_rd = 1; cycle("R9");
      cycle("R9");

      // R13 masked source recorded
      src_en[3] = 0; tx_evt = 1; cycle("R13");
      cycle("R13");
      src_en[3] = 1; cycle("R13");
      isr_rd = 1; cycle("R13");
      cycle("R13");

      // R2 randomized mix
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(15) == 0) fifo_en = 1'($urandom);
         if ($urandom_range(15) == 0) enh_en  = 1'($urandom);
         if ($urandom_range(31) == 0) src_en  = 7'($urandom);
         if ($urandom_range(3) == 0)  rx_level = 6'($urandom_range(20));
         if ($urandom_range(31) == 0) rx_trig  = 6'($urandom_range(16, 1));
         line_evt  = ($urandom_range(9) == 0);
         tmo_evt   = ($urandom_range(9) == 0);
         tx_evt    = ($urandom_range(7) == 0);
         modem_evt = ($urandom_range(9) == 0);
         xoff_evt  = ($urandom_range(11) == 0);
         xon_evt   = ($urandom_range(11) == 0);
         flow_evt  = ($urandom_range(11) == 0);
         isr_rd    = ($urandom_range(3) == 0);
         lsr_rd    = ($urandom_range(5) == 0);
         msr_rd    = ($urandom_range(5) == 0);
         rx_pop    = ($urandom_range(3) == 0);
         cycle("R2");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule